// File: doc/BRIEF.md
# Cache Performance Monitor Counter Unit

This unit counts hardware events on behalf of software that profiles a shared cache. It holds a parameterised set of general event counters (four by default) and one free-running cycle counter. Software reaches all of them through an indirect register port, which consists of a write address, write data and write strobe plus a read address, read strobe and registered read data. Events arrive on a single strobe together with a resource index, a group number and an 8-bit code. Each general counter chooses one resource and group through its event-type register. A shared bank of resource registers then supplies the code to match, one byte lane per group, and a per-resource enable bit.

A counter can be preloaded with the two's complement of a sampling period. It then wraps after exactly that many events, and the wrap latches a flag in the overflow register. A single level-sensitive interrupt is raised while any flagged counter also has its interrupt enable set. Each counter has a filter register and a count-control register. Both are kept for software to read back and have no effect on counting.

Top module: `perfmon_unit`

## Requirements
- R1: After reset all counters, enable masks, interrupt-enable masks, overflow flags and the control register read as zero, and `irq` is low.
- R2: `rd_data` shows the addressed register on the cycle after `rd_en` and holds otherwise. Unmapped addresses (for example 0x401) read as zero, and writes to them change nothing.
- R3: Counter enables form a mask in which bit i stands for general counter i and bit 31 stands for the cycle counter. Writing 1s to 0x403 sets those bits and writing 1s to 0x402 clears them. Zero bits and unimplemented bits are left unchanged, and a read of either address returns the mask.
- R4: Interrupt enables use the same bit layout, with the set address at 0x405 and the clear address at 0x404. They behave as in R3.
- R5: The control register at 0x400 holds the global count enable in bit 0. Writing bit 1 as 1 zeroes all general counters, and writing bit 2 as 1 zeroes the cycle counter, so 0x6 zeroes every counter. Bits 1 and 2 read back as zero. No counter advances while bit 0 is clear.
- R6: The cycle counter, read and written at 0x409, advances by one on every clock while bit 0 of the control register and bit 31 of the enable mask are both set. The status word at 0x40A reads 0x2 while it runs and 0 otherwise. The word at 0x408 is plain storage.
- R7: The event type of counter i lives at 0x424+16·i. Bits [1:0] hold the group and bits [3:2] hold the resource index, and only these bits are stored. Resource register r lives at 0x410+r. Bits [8g+7:8g] of that register hold the code for group g, and bit 31 is its enable.
- R8: A general counter advances by one on a cycle in which all of the following hold: global enable is set, its own enable bit is set, an event strobe arrives whose resource index and group equal its event type, that resource register's enable bit is set, and the strobe code equals the selected byte lane.
- R9: The value of counter i is at 0x421+16·i. A write there, or at 0x409, loads the counter and takes precedence over an increment in the same cycle.
- R10: A counter that advances past all ones wraps to zero and sets its bit in the overflow register at 0x406 (bit i, or bit 31 for the cycle counter).
- R11: Writing 1s to 0x406 clears those overflow flags. A wrap in the same cycle as such a clear leaves the flag set.
- R12: `irq` is high exactly while some overflow flag and its interrupt-enable bit are both set.
- R13: Filter registers (0x423+16·i) and count-control registers (0x420+16·i) store and return 32 bits and do not affect counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event strobe |
| ev_res | input | $clog2(NUM_RES) | Resource index of the event |
| ev_grp | input | 2 | Group of the event |
| ev_code | input | 8 | Event code within the group |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 12 | Register read address |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt on enabled overflow |

## Verification
The bench builds the unit with its defaults: four general counters, full 32-bit counters and four resource registers. Because counters can be loaded, a preload of 0xFFFFFFFE brings a 32-bit wrap within two events or two clocks, so overflow, same-cycle set-versus-clear and interrupt masking can all be reached without long runs. Four resources with four byte lanes each allow events that match on only part of the selection (resource, group, code, or resource enable), which checks each matching term separately.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
   localparam int ADDR_W  = 12;
   localparam int DATA_W  = 32;
   localparam int CYC_BIT = 31;
   localparam int LANE_W  = 8;

   typedef logic [ADDR_W-1:0] addr_t;
   typedef logic [DATA_W-1:0] word_t;

   localparam addr_t A_CTRL     = 12'h400;
   localparam addr_t A_EN_CLR   = 12'h402;
   localparam addr_t A_EN_SET   = 12'h403;
   localparam addr_t A_IE_CLR   = 12'h404;
   localparam addr_t A_IE_SET   = 12'h405;
   localparam addr_t A_OVF      = 12'h406;
   localparam addr_t A_CYC_CTL  = 12'h408;
   localparam addr_t A_CYC_VAL  = 12'h409;
   localparam addr_t A_CYC_STAT = 12'h40A;
   localparam addr_t A_RES_BASE = 12'h410;

   // per-counter page: addr[11:8] == PC_PAGE, addr[7:4] == PC_BLK0 + index
   localparam logic [3:0] PC_PAGE  = 4'h4;
   localparam int         PC_BLK0  = 2;
   localparam logic [3:0] SUB_CTL  = 4'h0;
   localparam logic [3:0] SUB_VAL  = 4'h1;
   localparam logic [3:0] SUB_FILT = 4'h3;
   localparam logic [3:0] SUB_TYPE = 4'h4;

   localparam int CTRL_GEN     = 0;
   localparam int CTRL_CLR_EV  = 1;
   localparam int CTRL_CLR_CYC = 2;

   localparam word_t CYC_RUNNING = 32'h2;
endpackage

// File: rtl/perfmon_ctr.sv
module perfmon_ctr #(
   parameter int W = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o,
   output logic         wrap_o
);
   logic [W-1:0] cnt_q;

   if (W < 2) begin : g_bad_w
      $error("perfmon_ctr: W must be at least 2");
   end

   // clear beats load, load beats increment
   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (ld_i)   cnt_q <= ld_val_i;
      else if (inc_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = inc_i && !clr_i && !ld_i && (&cnt_q);
endmodule

// File: rtl/perfmon_evmatch.sv
module perfmon_evmatch #(
   parameter int NUM_RES = 4,
   parameter int RES_W   = $clog2(NUM_RES),
   parameter int TYPE_W  = RES_W + 2
)(
   input  logic                  ev_valid,
   input  logic [RES_W-1:0]      ev_res,
   input  logic [1:0]            ev_grp,
   input  logic [7:0]            ev_code,
   input  logic [TYPE_W-1:0]     sel,
   input  logic [NUM_RES*32-1:0] res_flat,
   output logic                  hit
);
   logic [RES_W+4:0] lane_base;
   logic [RES_W+4:0] en_pos;
   logic [7:0]       lane_code;
   logic             res_on;

   if (TYPE_W != RES_W + 2) begin : g_bad_type
      $error("perfmon_evmatch: TYPE_W must equal RES_W + 2");
   end

   always_comb begin
      lane_base = {ev_res, ev_grp, 3'b000};
      en_pos    = {ev_res, 5'd31};
      lane_code = res_flat[lane_base +: 8];
      res_on    = res_flat[en_pos];
      hit = ev_valid && res_on
         && (ev_grp == sel[1:0])
         && (ev_res == sel[TYPE_W-1:2])
         && (ev_code == lane_code);
   end
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
   import perfmon_pkg::*;
#(
   parameter int NUM_EVT = 4,
   parameter int CNT_W   = 32,
   parameter int NUM_RES = 4
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ev_valid,
   input  logic [$clog2(NUM_RES)-1:0] ev_res,
   input  logic [1:0]                 ev_grp,
   input  logic [7:0]                 ev_code,
   input  logic                       wr_en,
   input  logic [11:0]                wr_addr,
   input  logic [31:0]                wr_data,
   input  logic                       rd_en,
   input  logic [11:0]                rd_addr,
   output logic [31:0]                rd_data,
   output logic                       irq
);
   localparam int RES_W  = $clog2(NUM_RES);
   localparam int TYPE_W = RES_W + 2;
   localparam word_t EV_MASK    = word_t'((64'd1 << NUM_EVT) - 64'd1);
   localparam word_t VALID_MASK = EV_MASK | (word_t'(1) << CYC_BIT);

   if (NUM_EVT < 1 || NUM_EVT > 12) begin : g_bad_evt
      $error("perfmon_unit: NUM_EVT must lie in 1..12");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("perfmon_unit: CNT_W must lie in 2..DATA_W");
   end
   if (NUM_RES < 2 || NUM_RES > 16 || (1 << RES_W) != NUM_RES) begin : g_bad_res
      $error("perfmon_unit: NUM_RES must be a power of two in 2..16");
   end

   logic              gen_q;
   word_t             en_q, ie_q, ovf_q, cyc_ctl_q;
   word_t             res_q   [NUM_RES];
   word_t             cctl_q  [NUM_EVT];
   word_t             filt_q  [NUM_EVT];
   logic [TYPE_W-1:0] etype_q [NUM_EVT];
   logic [CNT_W-1:0]  ev_cnt  [NUM_EVT];
   logic [CNT_W-1:0]  cyc_cnt;
   logic [NUM_EVT-1:0] ev_wrap, ev_hit, pc_wr;
   logic              cyc_wrap;
   logic [NUM_RES*32-1:0] res_flat;
   word_t             wrap_vec, ovf_clr, rd_mux;
   logic              wr_ctrl, clr_ev, clr_cyc, cyc_run;

   assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
   assign clr_ev  = wr_ctrl && wr_data[CTRL_CLR_EV];
   assign clr_cyc = wr_ctrl && wr_data[CTRL_CLR_CYC];
   assign cyc_run = gen_q && en_q[CYC_BIT];
   assign ovf_clr = (wr_en && (wr_addr == A_OVF)) ? (wr_data & VALID_MASK) : '0;

   always_comb begin
      for (int r = 0; r < NUM_RES; r++) res_flat[r*32 +: 32] = res_q[r];
   end

   // general event counters
   for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
      assign pc_wr[i] = wr_en && (wr_addr[11:8] == PC_PAGE)
                     && (wr_addr[7:4] == 4'(PC_BLK0 + i));

      perfmon_evmatch #(.NUM_RES(NUM_RES), .RES_W(RES_W), .TYPE_W(TYPE_W)) match_i (
         .ev_valid (ev_valid),
         .ev_res   (ev_res),
         .ev_grp   (ev_grp),
         .ev_code  (ev_code),
         .sel      (etype_q[i]),
         .res_flat (res_flat),
         .hit      (ev_hit[i])
      );

      perfmon_ctr #(.W(CNT_W)) ctr_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr_i    (clr_ev),
         .ld_i     (pc_wr[i] && (wr_addr[3:0] == SUB_VAL)),
         .ld_val_i (wr_data[CNT_W-1:0]),
         .inc_i    (gen_q && en_q[i] && ev_hit[i]),
         .cnt_o    (ev_cnt[i]),
         .wrap_o   (ev_wrap[i])
      );
   end

   // cycle counter
   perfmon_ctr #(.W(CNT_W)) cyc_ctr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clr_cyc),
      .ld_i     (wr_en && (wr_addr == A_CYC_VAL)),
      .ld_val_i (wr_data[CNT_W-1:0]),
      .inc_i    (cyc_run),
      .cnt_o    (cyc_cnt),
      .wrap_o   (cyc_wrap)
   );

   always_comb begin
      wrap_vec = '0;
      wrap_vec[NUM_EVT-1:0] = ev_wrap;
      wrap_vec[CYC_BIT]     = cyc_wrap;
   end

   // register file
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gen_q     <= 1'b0;
         en_q      <= '0;
         ie_q      <= '0;
         ovf_q     <= '0;
         cyc_ctl_q <= '0;
         for (int r = 0; r < NUM_RES; r++) res_q[r] <= '0;
         for (int i = 0; i < NUM_EVT; i++) begin
            cctl_q[i]  <= '0;
            filt_q[i]  <= '0;
            etype_q[i] <= '0;
         end
      end else begin
         if (wr_ctrl) gen_q <= wr_data[CTRL_GEN];
         if (wr_en && (wr_addr == A_EN_SET)) en_q <= en_q | (wr_data & VALID_MASK);
         if (wr_en && (wr_addr == A_EN_CLR)) en_q <= en_q & ~(wr_data & VALID_MASK);
         if (wr_en && (wr_addr == A_IE_SET)) ie_q <= ie_q | (wr_data & VALID_MASK);
         if (wr_en && (wr_addr == A_IE_CLR)) ie_q <= ie_q & ~(wr_data & VALID_MASK);
         if (wr_en && (wr_addr == A_CYC_CTL)) cyc_ctl_q <= wr_data;
         ovf_q <= (ovf_q & ~ovf_clr) | wrap_vec;
         for (int r = 0; r < NUM_RES; r++) begin
            if (wr_en && (wr_addr == A_RES_BASE + addr_t'(r))) res_q[r] <= wr_data;
         end
         for (int i = 0; i < NUM_EVT; i++) begin
            if (pc_wr[i] && (wr_addr[3:0] == SUB_CTL))  cctl_q[i]  <= wr_data;
            if (pc_wr[i] && (wr_addr[3:0] == SUB_FILT)) filt_q[i]  <= wr_data;
            if (pc_wr[i] && (wr_addr[3:0] == SUB_TYPE)) etype_q[i] <= wr_data[TYPE_W-1:0];
         end
      end
   end

   // read multiplexer
   always_comb begin
      rd_mux = '0;
      case (rd_addr)
         A_CTRL:               rd_mux = word_t'(gen_q);
         A_EN_CLR, A_EN_SET:   rd_mux = en_q;
         A_IE_CLR, A_IE_SET:   rd_mux = ie_q;
         A_OVF:                rd_mux = ovf_q;
         A_CYC_CTL:            rd_mux = cyc_ctl_q;
         A_CYC_VAL:            rd_mux = word_t'(cyc_cnt);
         A_CYC_STAT:           rd_mux = cyc_run ? CYC_RUNNING : '0;
         default:              rd_mux = '0;
      endcase
      if ((rd_addr[11:4] == A_RES_BASE[11:4]) && (int'(rd_addr[3:0]) < NUM_RES))
         rd_mux = res_q[rd_addr[RES_W-1:0]];
      for (int i = 0; i < NUM_EVT; i++) begin
         if ((rd_addr[11:8] == PC_PAGE) && (rd_addr[7:4] == 4'(PC_BLK0 + i))) begin
            case (rd_addr[3:0])
               SUB_CTL:  rd_mux = cctl_q[i];
               SUB_VAL:  rd_mux = word_t'(ev_cnt[i]);
               SUB_FILT: rd_mux = filt_q[i];
               SUB_TYPE: rd_mux = word_t'(etype_q[i]);
               default:  rd_mux = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_mux;
   end

   assign irq = |(ovf_q & ie_q);
endmodule

// File: rtl/perfmon_unit_chk.sv
module perfmon_unit_chk
   import perfmon_pkg::*;
#(
   parameter int CNT_W = 32
)(
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [11:0]      wr_addr,
   input logic [31:0]      wr_data,
   input logic             rd_en,
   input logic [11:0]      rd_addr,
   input logic [31:0]      rd_data,
   input logic             irq,
   input logic             gen_q,
   input logic [31:0]      en_q,
   input logic [31:0]      ovf_q,
   input logic [CNT_W-1:0] cyc_cnt
);
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == 12'h401) |=> (rd_data == 32'h0)); // R2

   AST_CTRL_CLEARS_CYC: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_CTRL && wr_data[CTRL_CLR_CYC]) |=> (cyc_cnt == '0)); // R5

   AST_CYC_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!gen_q && !wr_en) |=> $stable(cyc_cnt)); // R6

   AST_CYC_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_q && en_q[CYC_BIT] && !wr_en) |=> (cyc_cnt == CNT_W'($past(cyc_cnt) + 1'b1))); // R6

   AST_CYC_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_q && en_q[CYC_BIT] && !wr_en && (&cyc_cnt)) |=> ovf_q[CYC_BIT]); // R10

   AST_OVF_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_OVF && wr_data[CYC_BIT] && !(gen_q && en_q[CYC_BIT]))
      |=> !ovf_q[CYC_BIT]); // R11

   AST_IE_CLEAR_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_IE_CLR && wr_data == 32'hFFFF_FFFF) |=> !irq); // R12
endmodule

bind perfmon_unit perfmon_unit_chk #(.CNT_W(CNT_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .rd_en   (rd_en),
   .rd_addr (rd_addr),
   .rd_data (rd_data),
   .irq     (irq),
   .gen_q   (gen_q),
   .en_q    (en_q),
   .ovf_q   (ovf_q),
   .cyc_cnt (cyc_cnt)
);

// File: tb/perfmon_unit_tb_top.sv
module perfmon_unit_tb_top;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [11:0] addr;
      logic [31:0] exp;
      string       tag;
   } rd_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_valid = 1'b0;
   logic [1:0]  ev_res = '0;
   logic [1:0]  ev_grp = '0;
   logic [7:0]  ev_code = '0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [11:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq;

   int checks = 0;
   int errors = 0;
   rd_item_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   perfmon_unit dut_i (
      .clk(clk), .rst_n(rst_n),
      .ev_valid(ev_valid), .ev_res(ev_res), .ev_grp(ev_grp), .ev_code(ev_code),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .irq(irq)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
      rd_item_t it;
      it.addr = a; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic ev(input logic [1:0] r, input logic [1:0] g, input logic [7:0] c);
      ev_valid = 1'b1; ev_res = r; ev_grp = g; ev_code = c;
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   // monitor: compare each captured read against the queued expectation
   initial begin
      forever begin
         @(posedge clk);
         if (rd_en) begin
            @(negedge clk);
            if (sb_q.size() == 0) begin
               chk(rd_data, 32'hDEAD_BEEF, "R2 unexpected read");
            end else begin
               rd_item_t it;
               it = sb_q.pop_front();
               chk(rd_data, it.exp, it.tag);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk({31'b0, irq}, 32'h0, "R1 irq after reset");
      rd(12'h400, 32'h0, "R1 ctrl");
      rd(12'h403, 32'h0, "R1 enable mask");
      rd(12'h406, 32'h0, "R1 overflow");
      rd(12'h409, 32'h0, "R1 cycle counter");

      // R2 unmapped
      wr(12'h401, 32'hFFFF_FFFF);
      rd(12'h401, 32'h0, "R2 unmapped read");

      // R3 enable set/clear
      wr(12'h403, 32'h8000_0005);
      rd(12'h402, 32'h8000_0005, "R3 set then read clr addr");
      wr(12'h402, 32'h0000_0001);
      wr(12'h403, 32'h0000_0F00);
      rd(12'h403, 32'h8000_0004, "R3 clear and unimplemented bits");

      // R4 interrupt-enable set/clear
      wr(12'h405, 32'h8000_000F);
      wr(12'h404, 32'h0000_000E);
      rd(12'h405, 32'h8000_0001, "R4 ie mask");

      // R6 cycle counter runs for exactly 10 clocks
      rd(12'h40A, 32'h0, "R6 status idle");
      wr(12'h409, 32'd100);
      wr(12'h400, 32'h1);
      rd(12'h40A, 32'h2, "R6 status running");
      repeat (8) @(negedge clk);
      wr(12'h400, 32'h0);
      rd(12'h409, 32'd110, "R6 cycle count");
      rd(12'h40A, 32'h0, "R6 status stopped");
      wr(12'h408, 32'hA5A5_0001);
      rd(12'h408, 32'hA5A5_0001, "R6 cycle control storage");

      // R5 cycle reset via control bit 2
      wr(12'h400, 32'h4);
      rd(12'h409, 32'h0, "R5 cycle reset");
      rd(12'h400, 32'h0, "R5 reset bits read zero");

      // R10/R12/R11 cycle wrap
      wr(12'h409, 32'hFFFF_FFFE);
      wr(12'h400, 32'h1);
      @(negedge clk);
      wr(12'h400, 32'h0);
      rd(12'h406, 32'h8000_0000, "R10 cycle wrap flag");
      rd(12'h409, 32'h0, "R10 cycle wrapped to zero");
      chk({31'b0, irq}, 32'h1, "R12 irq on enabled flag");
      wr(12'h406, 32'h8000_0000);
      chk({31'b0, irq}, 32'h0, "R12 irq drops after clear");
      rd(12'h406, 32'h0, "R11 w1c");

      // R8 event matching
      wr(12'h402, 32'h8000_0000);
      wr(12'h411, 32'h8000_5A00);
      wr(12'h444, 32'h5);
      wr(12'h403, 32'h1);
      wr(12'h400, 32'h1);
      for (int k = 0; k < 3; k++) ev(2'd1, 2'd1, 8'h5A);
      ev(2'd1, 2'd1, 8'h5B);
      ev(2'd1, 2'd2, 8'h5A);
      ev(2'd0, 2'd1, 8'h5A);
      ev(2'd0, 2'd0, 8'h00);
      rd(12'h441, 32'd3, "R8 matching events counted");
      rd(12'h421, 32'd0, "R8 disabled resource not counted");
      rd(12'h424, 32'd0, "R7 counter0 type");
      rd(12'h444, 32'd5, "R7 counter2 type");

      // R5 global enable off
      wr(12'h400, 32'h0);
      ev(2'd1, 2'd1, 8'h5A);
      rd(12'h441, 32'd3, "R5 no count when global off");

      // R3 per-counter enable off
      wr(12'h400, 32'h1);
      wr(12'h402, 32'h4);
      ev(2'd1, 2'd1, 8'h5A);
      rd(12'h441, 32'd3, "R3 no count when counter disabled");
      wr(12'h403, 32'h4);

      // R7 resource enable and lane 0
      wr(12'h410, 32'h8000_0000);
      ev(2'd0, 2'd0, 8'h00);
      rd(12'h421, 32'd1, "R7 resource 0 lane 0");
      wr(12'h424, 32'hFF);
      rd(12'h424, 32'h0F, "R7 type width");
      wr(12'h424, 32'h0);

      // R10 preload wrap on event counter, R12 masking
      wr(12'h441, 32'hFFFF_FFFE);
      ev(2'd1, 2'd1, 8'h5A);
      ev(2'd1, 2'd1, 8'h5A);
      rd(12'h406, 32'h4, "R10 event counter wrap flag");
      chk({31'b0, irq}, 32'h0, "R12 irq masked");
      wr(12'h405, 32'h4);
      chk({31'b0, irq}, 32'h1, "R12 irq unmasked");
      wr(12'h406, 32'h1);
      rd(12'h406, 32'h4, "R11 other bit untouched");
      wr(12'h406, 32'h4);
      rd(12'h406, 32'h0, "R11 cleared");

      // R9 write beats increment
      wr_en = 1'b1; wr_addr = 12'h441; wr_data = 32'd50;
      ev(2'd1, 2'd1, 8'h5A);
      wr_en = 1'b0;
      rd(12'h441, 32'd50, "R9 load precedence");

      // R11 wrap wins over same-cycle clear
      wr(12'h441, 32'hFFFF_FFFF);
      ev(2'd1, 2'd1, 8'h5A);
      wr(12'h441, 32'hFFFF_FFFF);
      wr_en = 1'b1; wr_addr = 12'h406; wr_data = 32'h4;
      ev(2'd1, 2'd1, 8'h5A);
      wr_en = 1'b0;
      rd(12'h406, 32'h4, "R11 set wins");

      // R13 filter and count-control storage
      wr(12'h433, 32'h000F_003F);
      wr(12'h430, 32'h0000_0012);
      wr(12'h423, 32'h0000_0003);
      rd(12'h433, 32'h000F_003F, "R13 filter readback");
      rd(12'h430, 32'h0000_0012, "R13 control readback");
      ev(2'd0, 2'd0, 8'h00);
      rd(12'h421, 32'd2, "R13 filter has no effect");

      // R5 full reset with 0x6
      wr(12'h400, 32'h6);
      rd(12'h441, 32'h0, "R5 counter2 reset");
      rd(12'h421, 32'h0, "R5 counter0 reset");
      rd(12'h409, 32'h0, "R5 cycle reset");
      rd(12'h400, 32'h0, "R5 ctrl after reset");

      repeat (3) @(negedge clk);
      if (sb_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL R2 pending reads actual=%0d expected=0", sb_q.size());
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule